// File: doc/BRIEF.md
# Serial converter read controller

This block is the master side of a link to a 12-bit, eight-channel analog-to-digital converter. The converter's serial protocol is not plain SPI. A start request carries a channel number. The controller then builds a 4-bit channel code and shifts it out on the data line while chip select is still high. The converter keeps the last four bits it received before chip select falls.

After the code, the controller lowers chip select. It lets two clocks pass while the converter samples and then holds. It then captures the 12 result bits, most significant first. When the transaction ends it raises chip select, waits one serial clock period, and pulses done for one cycle.

When the verify option is set at the start, the controller keeps chip select low for eleven more clocks. During these clocks the converter replays the result least significant first. The controller compares this replay with the first copy and sets a mismatch flag on any disagreement. The serial clock runs at the system clock divided by a parameter.

Top module: `adc_seq_reader`

## Requirements
- R1: The serial clock idles low. Each of its half periods lasts CLK_DIV system clocks, counted from the cycle after the start is accepted. It toggles only while busy is high.
- R2: An accepted start drives the code {1'b1, chan_i} onto mosi_o, most significant bit first. This takes four serial clock pulses, all with cs_n_o high. The first bit appears at the acceptance edge, and each later bit changes only on a falling serial clock edge.
- R3: cs_n_o falls together with the falling edge of the fourth code pulse, while the serial clock is low. It then stays low for 14 serial clock pulses, or 25 pulses when verify is set.
- R4: miso_i is ignored on the first two pulses after cs_n_o falls. On the rising edges of pulses 3 to 14 it is sampled as result bits 11 down to 0.
- R5: With verify set, pulses 15 to 25 carry result bits 1 to 11 in that order. mismatch_o goes to 1 if any of them differs from the first copy. With verify clear, mismatch_o stays 0.
- R6: cs_n_o rises with the falling edge of the last pulse. Two half periods later, done_o is 1 for exactly one cycle and busy_o drops on the same edge. result_o and mismatch_o then hold their values until the next accepted start.
- R7: busy_o is 1 from the edge that accepts a start until the done edge. A start request, channel or verify value presented while busy is ignored.
- R8: During reset: cs_n_o=1, sclk_o=0, mosi_o=0, busy_o=0, done_o=0, result_o=0, mismatch_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, taken only while idle |
| chan_i | input | CH_W | Channel number sampled at start |
| verify_i | input | 1 | Read the least-significant-first replay and compare |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction strobe |
| result_o | output | RES_W | Captured conversion result |
| mismatch_o | output | 1 | Replay disagreed with the first copy |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| mosi_o | output | 1 | Channel code to the converter |
| miso_i | input | 1 | Serial data from the converter |

## Verification
The converter model drives ones during the two hold clocks. A design that sampled those clocks would shift the result and lose its low bits, and an all-zero result makes this plain.

Channel values of all zeros, all ones and a single set bit at either end expose an off-by-one between capture and comparison. Such a fault also shows up as a false mismatch in verify mode.

A corrupted replay bit must set the mismatch flag with verify on and must not with verify off. A start issued mid-transaction with a different channel must leave the waveform and the result unchanged. The reference model compares chip select, clock, data, busy and done on every cycle, so a misplaced edge or a missing gap is caught at the cycle where it happens.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial converter read controller.
package adc_rd_pkg;
    // Transaction phases of the read sequencer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_READ = 2'd2,
        ST_GAP  = 2'd3
    } rd_state_e;
endpackage

// File: rtl/adc_rd_tick.sv
`timescale 1ns/1ps
// Half-period tick generator.
// Emits one tick every CLK_DIV system clocks while run_i is high, and
// restarts from zero whenever run_i is low. Assumes CLK_DIV >= 2.
module adc_rd_tick #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int DW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

    logic [DW-1:0] cnt_q;

    // Count system clocks within one serial half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)
            cnt_q <= '0;
        else if (cnt_q == DW'(CLK_DIV - 1))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + DW'(1);
    end

    assign tick_o = run_i && (cnt_q == DW'(CLK_DIV - 1));

    generate
        if (CLK_DIV > 1) begin : g_spacing
            // R1: two ticks are never adjacent
            assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/adc_rd_fsm.sv
`timescale 1ns/1ps
// Transaction sequencer.
// Shifts the channel code out with chip select high, lowers chip select,
// counts the hold and data pulses, then waits one serial period and strobes
// done. Assumes tick_i arrives at most every other cycle.
module adc_rd_fsm
    import adc_rd_pkg::*;
#(
    parameter int CH_W      = 3,
    parameter int RES_W     = 12,
    parameter int HOLD_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic [CH_W-1:0] chan_i,
    input  logic verify_i,
    input  logic tick_i,
    output logic sclk_o,
    output logic cs_n_o,
    output logic mosi_o,
    output logic busy_o,
    output logic done_o,
    output logic clear_o,
    output logic sample_o,
    output logic [$clog2(HOLD_CLKS + 2*RES_W)-1:0] pulse_o
);
    localparam int CODE_W  = CH_W + 1;
    localparam int MSB_END = HOLD_CLKS + RES_W;
    localparam int LSB_END = MSB_END + RES_W - 1;
    localparam int IW      = $clog2(LSB_END + 1);

    rd_state_e         st_q;
    logic [IW-1:0]     cnt_q;
    logic [CODE_W-1:0] code_q;
    logic              sclk_q, cs_n_q, mosi_q, busy_q, done_q, vfy_q;
    logic [IW-1:0]     last_pulse;

    // Pick the final pulse number for the chosen read mode.
    always_comb last_pulse = vfy_q ? IW'(LSB_END) : IW'(MSB_END);

    // Sequence the phases and drive the converter pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            code_q <= '0;
            sclk_q <= 1'b0;
            cs_n_q <= 1'b1;
            mosi_q <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            vfy_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (start_i) begin
                    st_q   <= ST_CMD;
                    busy_q <= 1'b1;
                    vfy_q  <= verify_i;
                    code_q <= {1'b1, chan_i};
                    mosi_q <= 1'b1;
                    cnt_q  <= '0;
                end
                ST_CMD: if (tick_i) begin
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                    end else begin
                        sclk_q <= 1'b0;
                        if (cnt_q == IW'(CODE_W - 1)) begin
                            cs_n_q <= 1'b0;
                            mosi_q <= 1'b0;
                            cnt_q  <= '0;
                            st_q   <= ST_READ;
                        end else begin
                            cnt_q  <= cnt_q + IW'(1);
                            mosi_q <= code_q[CODE_W-2];
                            code_q <= {code_q[CODE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_READ: if (tick_i) begin
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        cnt_q  <= cnt_q + IW'(1);
                    end else begin
                        sclk_q <= 1'b0;
                        if (cnt_q == last_pulse) begin
                            cs_n_q <= 1'b1;
                            cnt_q  <= '0;
                            st_q   <= ST_GAP;
                        end
                    end
                end
                ST_GAP: if (tick_i) begin
                    if (cnt_q == IW'(1)) begin
                        st_q   <= ST_IDLE;
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                        cnt_q  <= '0;
                    end else begin
                        cnt_q <= cnt_q + IW'(1);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign sclk_o   = sclk_q;
    assign cs_n_o   = cs_n_q;
    assign mosi_o   = mosi_q;
    assign busy_o   = busy_q;
    assign done_o   = done_q;
    assign clear_o  = (st_q == ST_IDLE) && start_i;
    assign sample_o = tick_i && !sclk_q && (st_q == ST_READ);
    assign pulse_o  = cnt_q + IW'(1);

    // R3: chip select changes only while the serial clock is low
    assert_cs_edge_clk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cs_n_q) |-> !sclk_q);
    // R1: the serial clock moves only on a tick
    assert_sclk_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk_q) |-> $past(tick_i));
    // R1: quiet pins while idle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> (!sclk_q && cs_n_q));
    // R6: done comes with chip select high and busy released
    assert_done_cs_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (cs_n_q && !busy_q));
    // R6: done lasts one cycle
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/adc_rd_capture.sv
`timescale 1ns/1ps
// Result capture and replay comparison.
// Shifts in data pulses MSB first and compares each replay pulse against the
// stored bit of the same weight. Assumes pulse_i numbers pulses from 1 after
// chip select falls.
module adc_rd_capture #(
    parameter int RES_W     = 12,
    parameter int HOLD_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic sample_i,
    input  logic [$clog2(HOLD_CLKS + 2*RES_W)-1:0] pulse_i,
    input  logic miso_i,
    output logic [RES_W-1:0] result_o,
    output logic mismatch_o
);
    localparam int MSB_END = HOLD_CLKS + RES_W;
    localparam int IW      = $clog2(MSB_END + RES_W);
    localparam int RW      = $clog2(RES_W);

    logic [RES_W-1:0] res_q;
    logic             mism_q;
    logic [RW-1:0]    lsb_pos;
    logic             in_msb, in_lsb;

    // Classify the pulse and find the replayed bit's weight.
    always_comb begin
        in_msb  = (pulse_i > IW'(HOLD_CLKS)) && (pulse_i <= IW'(MSB_END));
        in_lsb  = pulse_i > IW'(MSB_END);
        lsb_pos = RW'(pulse_i - IW'(MSB_END));
    end

    // Store the first copy and flag replay disagreements.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            res_q  <= '0;
            mism_q <= 1'b0;
        end else if (sample_i) begin
            if (in_msb)
                res_q <= {res_q[RES_W-2:0], miso_i};
            else if (in_lsb && (miso_i != res_q[lsb_pos]))
                mism_q <= 1'b1;
        end
    end

    assign result_o   = res_q;
    assign mismatch_o = mism_q;

    // R4: sample and hold pulses leave the result untouched
    assert_hold_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && (pulse_i <= IW'(HOLD_CLKS))) |=> $stable(res_q));
    // R5: mismatch only rises on a replay pulse
    assert_mism_replay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mism_q) |-> $past(pulse_i > IW'(MSB_END)));
endmodule

// File: rtl/adc_seq_reader.sv
`timescale 1ns/1ps
// Serial converter read controller, top level.
// Joins the tick generator, sequencer and capture path. Assumes CLK_DIV >= 2
// and a converter that launches data on the falling serial clock edge.
module adc_seq_reader #(
    parameter int CLK_DIV   = 4,
    parameter int RES_W     = 12,
    parameter int CH_W      = 3,
    parameter int HOLD_CLKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic             verify_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o,
    output logic             mismatch_o,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             mosi_o,
    input  logic             miso_i
);
    localparam int IW = $clog2(HOLD_CLKS + 2*RES_W);

    logic          tick, clear, sample;
    logic [IW-1:0] pulse;

    adc_rd_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run_i(busy_o), .tick_o(tick)
    );

    adc_rd_fsm #(.CH_W(CH_W), .RES_W(RES_W), .HOLD_CLKS(HOLD_CLKS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .verify_i(verify_i), .tick_i(tick), .sclk_o(sclk_o), .cs_n_o(cs_n_o),
        .mosi_o(mosi_o), .busy_o(busy_o), .done_o(done_o), .clear_o(clear),
        .sample_o(sample), .pulse_o(pulse)
    );

    adc_rd_capture #(.RES_W(RES_W), .HOLD_CLKS(HOLD_CLKS)) u_cap (
        .clk(clk), .rst_n(rst_n), .clear_i(clear), .sample_i(sample),
        .pulse_i(pulse), .miso_i(miso_i), .result_o(result_o),
        .mismatch_o(mismatch_o)
    );
endmodule

// File: tb/sim_adc_seq_reader.sv
`timescale 1ns/1ps
// Bench: behavioural converter plus a cycle-count reference model.
module sim_adc_seq_reader;
    localparam int DIV = 4;

    logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, verify_i = 1'b0, miso_i = 1'b0;
    logic [2:0] chan_i = '0;
    logic busy_o, done_o, mismatch_o, cs_n_o, sclk_o, mosi_o;
    logic [11:0] result_o;

    adc_seq_reader #(.CLK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .verify_i(verify_i), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o), .mismatch_o(mismatch_o), .cs_n_o(cs_n_o),
        .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i)
    );

    always #2.5 clk = ~clk;

    int n_tests = 0, n_fail = 0;
    logic [11:0] vals [8];
    bit corrupt = 0;

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference model: elapsed edges since acceptance.
    bit m_busy = 0, m_done = 0, m_vfy = 0, m_cor = 0;
    int k = 0, m_chan = 0, m_res = 0, m_mis = 0;

    function automatic int n_pulses(bit v);
        return v ? 25 : 14;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_res = 0; m_mis = 0;
        end else begin
            m_done = 0;
            if (!m_busy) begin
                if (start_i) begin
                    m_busy = 1; k = 0; m_chan = int'(chan_i);
                    m_vfy = verify_i; m_cor = corrupt;
                end
            end else begin
                k++;
                if (k == (10 + 2*n_pulses(m_vfy)) * DIV) begin
                    m_busy = 0; m_done = 1;
                    m_res = int'(vals[m_chan]);
                    m_mis = (m_vfy && m_cor) ? 1 : 0;
                end
            end
        end
    end

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            int h, n, e_sclk, e_cs, e_mosi, e_busy, e_done;
            n = n_pulses(m_vfy);
            h = k / DIV;
            if (m_busy) begin
                e_sclk = ((h % 2) == 1 && h <= 7 + 2*n) ? 1 : 0;
                e_cs   = (h < 8 || h >= 8 + 2*n) ? 1 : 0;
                e_mosi = (h < 8) ? (((8 | m_chan) >> (3 - h/2)) & 1) : 0;
                e_busy = 1; e_done = 0;
            end else begin
                e_sclk = 0; e_cs = 1; e_mosi = 0; e_busy = 0;
                e_done = m_done ? 1 : 0;
            end
            chk("R1 sclk", int'(sclk_o), e_sclk);
            chk("R2 mosi", int'(mosi_o), e_mosi);
            chk("R3 cs_n", int'(cs_n_o), e_cs);
            chk("R7 busy", int'(busy_o), e_busy);
            chk("R6 done", int'(done_o), e_done);
            if (m_done) begin
                chk("R4 result", int'(result_o), m_res);
                chk("R5 mismatch", int'(mismatch_o), m_mis);
            end
        end
    end

    // Converter model: latches code, launches data after falling clock edges.
    logic [3:0] cv_sh = '0, cv_code = '0;
    logic prev_cs = 1'b1, prev_sclk = 1'b0;
    int p = 0;

    function automatic logic cbit(int q);
        logic [11:0] v;
        v = vals[cv_code[2:0]];
        if (q <= 2)  return 1'b1;
        if (q <= 14) return v[14 - q];
        if (q <= 25) return v[q - 14] ^ ((corrupt && q == 19) ? 1'b1 : 1'b0);
        return 1'b0;
    endfunction

    always @(negedge clk) begin
        if (prev_cs && !cs_n_o) begin
            p = 0; cv_code = cv_sh; miso_i = cbit(1);
        end else if (!cs_n_o && prev_sclk && !sclk_o) begin
            p++; miso_i = cbit(p + 1);
        end else if (cs_n_o && !prev_sclk && sclk_o) begin
            cv_sh = {cv_sh[2:0], mosi_o};
        end
        prev_cs = cs_n_o;
        prev_sclk = sclk_o;
    end

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic pulse_start(int ch, bit vf);
        chan_i = 3'(ch); verify_i = vf; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        while (done_o !== 1'b1) @(negedge clk);
    endtask

    task automatic run(int ch, bit vf, bit cor);
        @(negedge clk);
        corrupt = cor;
        pulse_start(ch, vf);
        wait_done();
        repeat (4) @(negedge clk);
        chk("R6 result held", int'(result_o), int'(vals[ch]));
        chk("R6 mismatch held", int'(mismatch_o), (vf && cor) ? 1 : 0);
    endtask

    initial begin
        vals[0] = 12'h000; vals[1] = 12'hFFF; vals[2] = 12'hA5A; vals[3] = 12'h001;
        vals[4] = 12'h800; vals[5] = 12'h5A5; vals[6] = 12'h7FE; vals[7] = 12'h3C3;
        repeat (3) @(negedge clk);
        chk("R8 cs_n", int'(cs_n_o), 1);
        chk("R8 sclk", int'(sclk_o), 0);
        chk("R8 mosi", int'(mosi_o), 0);
        chk("R8 busy", int'(busy_o), 0);
        chk("R8 done", int'(done_o), 0);
        chk("R8 result", int'(result_o), 0);
        chk("R8 mismatch", int'(mismatch_o), 0);
        rst_n = 1'b1;
        run(0, 0, 0);
        run(1, 0, 0);
        run(2, 1, 0);
        run(3, 1, 1);   // R5: corrupted replay flagged
        run(4, 0, 1);   // R5: corruption unseen without verify
        run(7, 1, 0);
        // R7: start request while busy is ignored
        @(negedge clk);
        corrupt = 0;
        pulse_start(5, 0);
        repeat (30) @(negedge clk);
        pulse_start(6, 1);
        wait_done();
        chk("R7 ignored start result", int'(result_o), int'(vals[5]));
        // R6/R7: back-to-back start taken on the cycle after done
        pulse_start(6, 1);
        wait_done();
        pulse_start(2, 0);
        wait_done();
        chk("R6 back-to-back result", int'(result_o), int'(vals[2]));
        repeat (10) @(negedge clk);
        chk("R1 idle sclk", int'(sclk_o), 0);
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R7 watchdog: actual busy %0d expected done", busy_o);
        finish_up();
    end
endmodule